// File: doc/BRIEF.md
# Debug Serial Port with Register Interface

This block is a small serial port for debug consoles. Software programs it through a flat 32-bit register bus made of address, write enable, write data, read enable and read data. It sends and receives 8-bit characters on a pair of serial pins. Frames use one start bit, eight data bits sent least significant bit first, an optional parity bit and one stop bit. A 16-bit divisor sets the bit rate. Each bit lasts sixteen divided ticks, so one bit takes 16 × divisor system clocks.

The receiver checks each frame for framing, parity and overrun errors. These error flags stay set until software clears them. A single interrupt line is raised when any status flag is set and its mask bit is also set. The mask has separate set and clear registers and can be read back.

Four routing modes help with bring-up. Normal mode connects the pins directly. Echo mode sends the receive pin back out on the transmit pin. Local loopback feeds the transmitter into the receiver and holds the pin high. Remote loopback wires the receive pin to the transmit pin and cuts off both internal engines.

Top module: `dbg_uart`

## Requirements
- R1: After reset, status reads 0x202, the mask reads 0, `tx_pin` is high and `irq` is low. Register offsets: control 0x00, mode 0x04, mask-set 0x08, mask-clear 0x0C, mask 0x10, status 0x14, receive data 0x18, transmit data 0x1C, divisor 0x20.
- R2: Writing ones to 0x08 sets mask bits and writing ones to 0x0C clears them. Only status positions 0, 1, 5, 6, 7 and 9 can be set (mask value 0x2E3), and 0x10 reads back the current mask.
- R3: `irq` is high exactly when some status bit and its mask bit are both 1.
- R4: A transmitted frame is a low start bit, then data bits 7:0 from bit 0 upward, then the parity bit if one is selected, then a high stop bit. Each bit lasts 16 × divisor clocks, and the line idles high.
- R5: Mode bits 11:9 select parity. Code 0 gives even parity, 1 odd, 2 a bit forced to 0, 3 a bit forced to 1, and 4 to 7 send no parity bit. The receiver uses the same code.
- R6: Status bit 1 (transmit ready) is 0 from a write to 0x1C until the character enters the shift register. Status bit 9 (transmitter empty) is 1 only when the holding register and the shift register are both idle.
- R7: The receiver confirms the start bit at mid-bit, so a low pulse shorter than half a bit is ignored. It takes each bit as the majority of three mid-bit samples and sets status bit 0 with the character in bits 7:0 of 0x18. A read of 0x18 with read enable clears bit 0.
- R8: Status bit 5 (overrun) is set when a character completes while bit 0 is still 1, and the newer character replaces the held one. Bit 6 is set when the stop bit is sampled low, and bit 7 on a parity mismatch. All three stay set until control bit 8 is written as one.
- R9: Control bits 4 and 5 enable and disable the receiver, and bits 6 and 7 enable and disable the transmitter. Both start disabled. A disabled receiver ignores the line, and a disabled transmitter keeps its character in the holding register.
- R10: Control bit 2 aborts any receive in progress and clears status bit 0. Control bit 3 aborts any transmit in progress, empties the holding register, drives the line high and sets status bits 1 and 9.
- R11: Mode bits 15:14 select routing. Code 0 is normal, 1 is echo (receive pin copied to the transmit pin and still received), 2 is local loopback (transmitter fed to the receiver, pin held high), and 3 is remote loopback (receive pin copied to the transmit pin, receiver sees an idle line).
- R12: The divisor sits in bits 15:0 of 0x20. A divisor of 0 stops the bit clock, so no bit is sent or sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Register byte offset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_en | input | 1 | Read strobe; with offset 0x18 it consumes the received character |
| rd_data | output | 32 | Combinational read value of the addressed register |
| rx_pin | input | 1 | Serial receive line |
| tx_pin | output | 1 | Serial transmit line |
| irq | output | 1 | Masked status interrupt |

## Verification
Register writes take effect at the next clock edge. Read data depends combinationally on `addr`, so the bench samples it one time step after driving the address on a falling edge. A character written for transmission starts on the first divided tick, which comes at most one divisor period later. The bench therefore waits for the falling start edge and then samples every bit at its centre, half a bit and then one bit period apart. Received flags appear two synchroniser stages plus about ten ticks into the stop bit. The bench holds a full stop bit and an idle bit before it reads status, so every check falls safely after that point. Echo and remote routing have no register in the path, so `tx_pin` is checked one time step after `rx_pin` changes.

// File: rtl/dbg_uart_pkg.sv
package dbg_uart_pkg;
    localparam int CHAR_W = 8;
    localparam int STAT_W = 10;

    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_MODE = 8'h04;
    localparam logic [7:0] OFS_MSET = 8'h08;
    localparam logic [7:0] OFS_MCLR = 8'h0C;
    localparam logic [7:0] OFS_MASK = 8'h10;
    localparam logic [7:0] OFS_STAT = 8'h14;
    localparam logic [7:0] OFS_RXD  = 8'h18;
    localparam logic [7:0] OFS_TXD  = 8'h1C;
    localparam logic [7:0] OFS_BAUD = 8'h20;

    localparam int CB_RXRST = 2;
    localparam int CB_TXRST = 3;
    localparam int CB_RXON  = 4;
    localparam int CB_RXOFF = 5;
    localparam int CB_TXON  = 6;
    localparam int CB_TXOFF = 7;
    localparam int CB_CLERR = 8;

    localparam int SB_RXRDY = 0;
    localparam int SB_TXRDY = 1;
    localparam int SB_OVR   = 5;
    localparam int SB_FRM   = 6;
    localparam int SB_PAR   = 7;
    localparam int SB_TXEMP = 9;
    localparam logic [STAT_W-1:0] STAT_VALID = 10'h2E3;

    localparam int MODE_PAR_LSB = 9;
    localparam int MODE_CH_LSB  = 14;

    typedef enum logic [1:0] {
        CH_NORMAL = 2'd0,
        CH_ECHO   = 2'd1,
        CH_LOCAL  = 2'd2,
        CH_REMOTE = 2'd3
    } chan_mode_e;

    function automatic logic par_enabled(input logic [2:0] pm);
        return pm < 3'd4;
    endfunction

    function automatic logic par_value(input logic [2:0] pm, input logic [CHAR_W-1:0] d);
        case (pm)
            3'd0:    return ^d;
            3'd1:    return ~(^d);
            3'd2:    return 1'b0;
            3'd3:    return 1'b1;
            default: return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/dbg_uart_tx.sv
module dbg_uart_tx
    import dbg_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              abort,
    input  logic              start,
    input  logic [CHAR_W-1:0] data,
    input  logic [2:0]        par_mode,
    output logic              line,
    output logic              busy
);
    localparam int FRAME_W = CHAR_W + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic               busy;
        logic [3:0]         phase;
        logic [CNT_W-1:0]   left;
        logic [FRAME_W-1:0] sh;
    } tx_st_t;

    tx_st_t q, d;

    always_comb begin
        d = q;
        if (abort) begin
            d.busy = 1'b0;
            d.sh   = '1;
        end else if (start) begin
            d.busy  = 1'b1;
            d.phase = '0;
            if (par_enabled(par_mode)) begin
                d.sh   = {1'b1, par_value(par_mode, data), data, 1'b0};
                d.left = CNT_W'(FRAME_W);
            end else begin
                d.sh   = {2'b11, data, 1'b0};
                d.left = CNT_W'(FRAME_W - 1);
            end
        end else if (q.busy && tick) begin
            d.phase = q.phase + 4'd1;
            if (q.phase == 4'hF) begin
                d.sh   = {1'b1, q.sh[FRAME_W-1:1]};
                d.left = q.left - 1'b1;
                if (q.left == CNT_W'(1)) d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{busy: 1'b0, phase: '0, left: '0, sh: '1};
        else        q <= d;
    end

    assign line = q.busy ? q.sh[0] : 1'b1;
    assign busy = q.busy;
endmodule

// File: rtl/dbg_uart_rx.sv
module dbg_uart_rx
    import dbg_uart_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              enable,
    input  logic              abort,
    input  logic              line,
    input  logic [2:0]        par_mode,
    output logic              done,
    output logic [CHAR_W-1:0] data,
    output logic              frm_err,
    output logic              par_err
);
    typedef enum logic {RX_IDLE, RX_BUSY} rx_state_e;

    typedef struct packed {
        rx_state_e         state;
        logic [3:0]        phase;
        logic [3:0]        idx;
        logic [1:0]        smp;
        logic [CHAR_W-1:0] shreg;
        logic              pbit;
        logic              done;
        logic              ferr;
        logic              perr;
    } rx_st_t;

    rx_st_t q, d;
    logic   vote;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        vote   = (q.smp[1] & q.smp[0]) | (q.smp[1] & line) | (q.smp[0] & line);
        if (abort || !enable) begin
            d.state = RX_IDLE;
        end else if (q.state == RX_IDLE) begin
            if (!line) begin
                d.state = RX_BUSY;
                d.phase = '0;
                d.idx   = '0;
            end
        end else if (tick) begin
            d.phase = q.phase + 4'd1;
            if (q.phase == 4'd7 || q.phase == 4'd8) d.smp = {q.smp[0], line};
            if (q.phase == 4'd9) begin
                d.idx = q.idx + 4'd1;
                if (q.idx == 4'd0) begin
                    if (vote) d.state = RX_IDLE;
                end else if (q.idx <= 4'(CHAR_W)) begin
                    d.shreg = {vote, q.shreg[CHAR_W-1:1]};
                end else if (q.idx == 4'(CHAR_W + 1) && par_enabled(par_mode)) begin
                    d.pbit = vote;
                end else begin
                    d.state = RX_IDLE;
                    d.done  = 1'b1;
                    d.ferr  = !vote;
                    d.perr  = par_enabled(par_mode) && (q.pbit != par_value(par_mode, q.shreg));
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{state: RX_IDLE, phase: '0, idx: '0, smp: '1, shreg: '0,
                           pbit: 1'b0, done: 1'b0, ferr: 1'b0, perr: 1'b0};
        else        q <= d;
    end

    assign done    = q.done;
    assign data    = q.shreg;
    assign frm_err = q.ferr;
    assign par_err = q.perr;
endmodule

// File: rtl/dbg_uart.sv
module dbg_uart
    import dbg_uart_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DIV_W  = 16,
    parameter int SYNC_N = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    input  logic              rx_pin,
    output logic              tx_pin,
    output logic              irq
);
    typedef struct packed {
        logic              rx_en;
        logic              tx_en;
        logic [2:0]        par;
        chan_mode_e        chm;
        logic [DIV_W-1:0]  div;
        logic [DIV_W-1:0]  bcnt;
        logic [STAT_W-1:0] mask;
        logic [CHAR_W-1:0] thr;
        logic              thr_full;
        logic [CHAR_W-1:0] rhr;
        logic              rxrdy;
        logic              ovr;
        logic              frm;
        logic              perr;
        logic [SYNC_N-1:0] sync;
    } top_st_t;

    top_st_t q, d;

    logic wr_ctrl, wr_mode, wr_mset, wr_mclr, wr_txd, wr_baud, rd_rxd;
    logic tick, tx_clr, rx_clr, tx_start, tx_line, tx_busy, rx_raw;
    logic rx_done, rx_ferr, rx_perr;
    logic [CHAR_W-1:0] rx_data;
    logic [STAT_W-1:0] stat;

    assign wr_ctrl = wr_en && addr == ADDR_W'(OFS_CTRL);
    assign wr_mode = wr_en && addr == ADDR_W'(OFS_MODE);
    assign wr_mset = wr_en && addr == ADDR_W'(OFS_MSET);
    assign wr_mclr = wr_en && addr == ADDR_W'(OFS_MCLR);
    assign wr_txd  = wr_en && addr == ADDR_W'(OFS_TXD);
    assign wr_baud = wr_en && addr == ADDR_W'(OFS_BAUD);
    assign rd_rxd  = rd_en && addr == ADDR_W'(OFS_RXD);

    assign tick     = (q.div != '0) && (q.bcnt == q.div - 1'b1);
    assign rx_clr   = wr_ctrl && wr_data[CB_RXRST];
    assign tx_clr   = wr_ctrl && wr_data[CB_TXRST];
    assign tx_start = q.thr_full && !tx_busy && q.tx_en && tick && !tx_clr;

    always_comb begin
        case (q.chm)
            CH_LOCAL:  rx_raw = tx_line;
            CH_REMOTE: rx_raw = 1'b1;
            default:   rx_raw = rx_pin;
        endcase
        case (q.chm)
            CH_NORMAL: tx_pin = tx_line;
            CH_LOCAL:  tx_pin = 1'b1;
            default:   tx_pin = rx_pin;
        endcase
    end

    dbg_uart_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .abort(tx_clr), .start(tx_start),
        .data(q.thr), .par_mode(q.par), .line(tx_line), .busy(tx_busy)
    );

    dbg_uart_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .enable(q.rx_en), .abort(rx_clr),
        .line(q.sync[SYNC_N-1]), .par_mode(q.par), .done(rx_done), .data(rx_data),
        .frm_err(rx_ferr), .par_err(rx_perr)
    );

    always_comb begin
        stat           = '0;
        stat[SB_RXRDY] = q.rxrdy;
        stat[SB_TXRDY] = !q.thr_full;
        stat[SB_OVR]   = q.ovr;
        stat[SB_FRM]   = q.frm;
        stat[SB_PAR]   = q.perr;
        stat[SB_TXEMP] = !q.thr_full && !tx_busy;
    end

    always_comb begin
        d      = q;
        d.sync = {q.sync[SYNC_N-2:0], rx_raw};
        d.bcnt = (q.div == '0 || tick) ? '0 : q.bcnt + 1'b1;
        if (wr_ctrl) begin
            if (wr_data[CB_RXON])  d.rx_en = 1'b1;
            if (wr_data[CB_RXOFF]) d.rx_en = 1'b0;
            if (wr_data[CB_TXON])  d.tx_en = 1'b1;
            if (wr_data[CB_TXOFF]) d.tx_en = 1'b0;
            if (wr_data[CB_CLERR]) begin
                d.ovr  = 1'b0;
                d.frm  = 1'b0;
                d.perr = 1'b0;
            end
            if (wr_data[CB_RXRST]) d.rxrdy    = 1'b0;
            if (wr_data[CB_TXRST]) d.thr_full = 1'b0;
        end
        if (wr_mode) begin
            d.par = wr_data[MODE_PAR_LSB +: 3];
            d.chm = chan_mode_e'(wr_data[MODE_CH_LSB +: 2]);
        end
        if (wr_mset) d.mask = q.mask | (wr_data[STAT_W-1:0] & STAT_VALID);
        if (wr_mclr) d.mask = q.mask & ~wr_data[STAT_W-1:0];
        if (wr_baud) begin
            d.div  = wr_data[DIV_W-1:0];
            d.bcnt = '0;
        end
        if (tx_start) d.thr_full = 1'b0;
        if (wr_txd) begin
            d.thr      = wr_data[CHAR_W-1:0];
            d.thr_full = 1'b1;
        end
        if (rd_rxd) d.rxrdy = 1'b0;
        if (rx_done) begin
            d.rhr   = rx_data;
            d.ovr   = d.ovr | d.rxrdy;
            d.rxrdy = 1'b1;
            d.frm   = d.frm | rx_ferr;
            d.perr  = d.perr | rx_perr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{rx_en: 1'b0, tx_en: 1'b0, par: '0, chm: CH_NORMAL, div: '0,
                           bcnt: '0, mask: '0, thr: '0, thr_full: 1'b0, rhr: '0,
                           rxrdy: 1'b0, ovr: 1'b0, frm: 1'b0, perr: 1'b0, sync: '1};
        else        q <= d;
    end

    always_comb begin
        case (addr)
            ADDR_W'(OFS_MODE): rd_data = (32'(q.par) << MODE_PAR_LSB) | (32'(q.chm) << MODE_CH_LSB);
            ADDR_W'(OFS_MASK): rd_data = 32'(q.mask);
            ADDR_W'(OFS_STAT): rd_data = 32'(stat);
            ADDR_W'(OFS_RXD):  rd_data = 32'(q.rhr);
            ADDR_W'(OFS_BAUD): rd_data = 32'(q.div);
            default:           rd_data = '0;
        endcase
    end

    assign irq = |(stat & q.mask);
endmodule

// File: rtl/dbg_uart_chk.sv
module dbg_uart_chk
    import dbg_uart_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DIV_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wr_en,
    input logic [31:0]       wr_data,
    input logic              rd_en,
    input logic              irq,
    input logic              tx_pin,
    input logic              tx_line,
    input logic              tx_clr,
    input logic [STAT_W-1:0] stat,
    input logic [STAT_W-1:0] mask,
    input logic [1:0]        chm,
    input logic [DIV_W-1:0]  div,
    input logic              rx_done
);
    logic ctrl_wr;
    assign ctrl_wr = wr_en && addr == ADDR_W'(OFS_CTRL);

    p_irq_needs_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask != '0));

    p_empty_implies_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stat[SB_TXEMP] |-> stat[SB_TXRDY]);

    p_read_clears_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_W'(OFS_RXD) && !rx_done) |=> !stat[SB_RXRDY]);

    p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[SB_OVR] && !(ctrl_wr && wr_data[CB_CLERR])) |=> stat[SB_OVR]);

    p_tx_reset_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data[CB_TXRST]) |=> (stat[SB_TXRDY] && stat[SB_TXEMP] && tx_line));

    p_local_pin_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (chm == 2'(CH_LOCAL)) |-> tx_pin);

    p_div_zero_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (div == '0 && !(wr_en && addr == ADDR_W'(OFS_BAUD)) && !tx_clr) |=> $stable(tx_line));
endmodule

bind dbg_uart dbg_uart_chk #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .irq(irq), .tx_pin(tx_pin), .tx_line(tx_line), .tx_clr(tx_clr),
    .stat(stat), .mask(q.mask), .chm(q.chm), .div(q.div), .rx_done(rx_done)
);

// File: tb/dbg_uart_tb_top.sv
module dbg_uart_tb_top;
    localparam int DIV = 2;
    localparam int BIT = 16 * DIV;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0, rx_pin = 1'b1;
    logic [31:0] wr_data = '0, rd_data, v;
    logic        tx_pin, irq;
    int          nvec = 0, nfail = 0;

    always #10 clk = ~clk;

    dbg_uart dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .rx_pin(rx_pin), .tx_pin(tx_pin), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] dv);
        @(negedge clk);
        addr = a; wr_data = dv; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic logic exp_par(input int pm, input logic [7:0] b);
        int ones = $countones(b);
        case (pm)
            0:       return logic'(ones % 2);
            1:       return logic'(1 - ones % 2);
            3:       return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic send(input logic [7:0] b, input int pm, input bit flip_par, input bit bad_stop);
        rx_pin = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_pin = b[i];
            repeat (BIT) @(negedge clk);
        end
        if (pm < 4) begin
            rx_pin = exp_par(pm, b) ^ flip_par;
            repeat (BIT) @(negedge clk);
        end
        rx_pin = !bad_stop;
        repeat (BIT) @(negedge clk);
        rx_pin = 1'b1;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic capture(input int pm, output logic [7:0] b, output logic p, output logic s);
        int t = 0;
        b = '0; p = 1'b0;
        while (tx_pin !== 1'b0 && t < 4000) begin
            @(negedge clk);
            t++;
        end
        chk("R4 start bit seen", 32'(t < 4000), 32'd1);
        repeat (BIT / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (BIT) @(negedge clk);
            b[i] = tx_pin;
        end
        if (pm < 4) begin
            repeat (BIT) @(negedge clk);
            p = tx_pin;
        end
        repeat (BIT) @(negedge clk);
        s = tx_pin;
        repeat (BIT) @(negedge clk);
    endtask

    task automatic count_low(input int cycles, output int lows);
        lows = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (tx_pin !== 1'b1) lows++;
        end
    endtask

    initial begin
        logic [7:0] cb;
        logic       cp, cs;
        int         lows;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h14); chk("R1 status after reset", v, 32'h202);
        rd(8'h10); chk("R1 mask after reset", v, 32'h0);
        chk("R1 tx idle", 32'(tx_pin), 32'd1);
        chk("R1 irq low", 32'(irq), 32'd0);

        // R2 mask set and clear
        wr(8'h08, 32'hFFFF_FFFF); rd(8'h10); chk("R2 mask set valid bits", v, 32'h2E3);
        wr(8'h0C, 32'h0000_0003); rd(8'h10); chk("R2 mask clear", v, 32'h2E0);
        // R3 irq from TX-empty bit and its mask
        chk("R3 irq with empty unmasked", 32'(irq), 32'd1);
        wr(8'h0C, 32'hFFFF_FFFF);
        chk("R3 irq all masked", 32'(irq), 32'd0);
        wr(8'h08, 32'h1);
        chk("R3 irq rxrdy masked but clear", 32'(irq), 32'd0);
        wr(8'h0C, 32'hFFFF_FFFF);

        // R12 divisor field width
        wr(8'h20, 32'h0001_0000 | DIV); rd(8'h20); chk("R12 divisor bits 15:0", v, 32'(DIV));

        // R9 / R6 disabled transmitter holds the character
        wr(8'h1C, 32'h3C);
        rd(8'h14); chk("R6 txrdy and empty low while held", v & 32'h202, 32'h0);
        count_low(4 * BIT, lows); chk("R9 disabled tx keeps line high", 32'(lows), 32'd0);
        wr(8'h00, 32'h40);
        capture(0, cb, cp, cs);
        chk("R9 held char sent after enable", 32'(cb), 32'h3C);
        rd(8'h14); chk("R6 flags back after frame", v & 32'h202, 32'h202);

        // R4 / R5 transmit sweep over parity codes and data
        for (int pm = 0; pm < 5; pm++) begin
            for (int k = 0; k < 6; k++) begin
                logic [7:0] b;
                b = 8'(k * 51 + pm);
                wr(8'h04, 32'(pm) << 9);
                wr(8'h1C, 32'(b));
                rd(8'h14); chk("R6 empty low during frame", v & 32'h200, 32'h0);
                capture(pm, cb, cp, cs);
                chk("R4 tx data bits", 32'(cb), 32'(b));
                if (pm < 4) chk("R5 tx parity bit", 32'(cp), 32'(exp_par(pm, b)));
                chk("R4 tx stop bit", 32'(cs), 32'd1);
            end
        end

        // R12 divisor zero freezes; R10 tx reset restores flags
        wr(8'h20, 32'h0);
        wr(8'h1C, 32'h81);
        count_low(200, lows); chk("R12 no bits at divisor 0", 32'(lows), 32'd0);
        rd(8'h14); chk("R12 char still held", v & 32'h202, 32'h0);
        wr(8'h00, 32'h08);
        rd(8'h14); chk("R10 tx reset flags", v & 32'h202, 32'h202);
        wr(8'h20, 32'(DIV));
        wr(8'h04, 32'h0);
        wr(8'h1C, 32'h00);
        repeat (3 * BIT) @(negedge clk);
        wr(8'h00, 32'h08);
        chk("R10 tx abort line high", 32'(tx_pin), 32'd1);
        rd(8'h14); chk("R10 tx abort flags", v & 32'h202, 32'h202);

        // R9 disabled receiver ignores the line
        send(8'h5A, 0, 1'b0, 1'b0);
        rd(8'h14); chk("R9 disabled rx no char", v & 32'h1, 32'h0);
        wr(8'h00, 32'h10);

        // R7 / R5 receive sweep
        for (int pm = 0; pm < 5; pm++) begin
            for (int k = 0; k < 6; k++) begin
                logic [7:0] b;
                b = 8'(k * 51 + 7 * pm);
                wr(8'h04, 32'(pm) << 9);
                send(b, pm, 1'b0, 1'b0);
                rd(8'h14); chk("R7 rx ready no errors", v & 32'hE1, 32'h01);
                rd(8'h18); chk("R7 rx data", v, 32'(b));
                rd(8'h14); chk("R7 read clears ready", v & 32'h1, 32'h0);
            end
        end

        // R8 parity error, sticky, irq, clear
        wr(8'h04, 32'h1 << 9);
        send(8'h96, 1, 1'b1, 1'b0);
        rd(8'h14); chk("R8 parity error flag", v & 32'hE1, 32'h81);
        rd(8'h18); chk("R8 data despite parity error", v, 32'h96);
        wr(8'h08, 32'h80);
        chk("R3 irq on parity error", 32'(irq), 32'd1);
        wr(8'h00, 32'h100);
        rd(8'h14); chk("R8 clear errors", v & 32'hE0, 32'h0);
        chk("R3 irq after clear", 32'(irq), 32'd0);
        wr(8'h0C, 32'hFFFF_FFFF);

        // R8 framing error
        wr(8'h04, 32'h4 << 9);
        send(8'h42, 4, 1'b0, 1'b1);
        rd(8'h14); chk("R8 framing flag", v & 32'h40, 32'h40);
        rd(8'h18); chk("R8 framing data", v, 32'h42);
        wr(8'h00, 32'h100);

        // R8 overrun
        send(8'h11, 4, 1'b0, 1'b0);
        send(8'h22, 4, 1'b0, 1'b0);
        rd(8'h14); chk("R8 overrun flag", v & 32'h21, 32'h21);
        rd(8'h18); chk("R8 newer char kept", v, 32'h22);
        rd(8'h14); chk("R8 overrun sticky after read", v & 32'h20, 32'h20);
        wr(8'h00, 32'h100);

        // R7 short low pulse rejected
        rx_pin = 1'b0;
        repeat (3) @(negedge clk);
        rx_pin = 1'b1;
        repeat (3 * BIT) @(negedge clk);
        rd(8'h14); chk("R7 glitch rejected", v & 32'h1, 32'h0);

        // R10 rx reset
        send(8'h77, 4, 1'b0, 1'b0);
        rd(8'h14); chk("R10 char before rx reset", v & 32'h1, 32'h1);
        wr(8'h00, 32'h04);
        rd(8'h14); chk("R10 rx reset clears ready", v & 32'h1, 32'h0);

        // R11 local loopback
        wr(8'h04, 32'h2 << 14);
        wr(8'h1C, 32'hC3);
        count_low(13 * BIT, lows); chk("R11 local pin held high", 32'(lows), 32'd0);
        rd(8'h14); chk("R11 local loop received", v & 32'hE1, 32'h01);
        rd(8'h18); chk("R11 local loop data", v, 32'hC3);

        // R11 echo
        wr(8'h04, 32'h1 << 14);
        rx_pin = 1'b0;
        #1 chk("R11 echo low", 32'(tx_pin), 32'd0);
        rx_pin = 1'b1;
        #1 chk("R11 echo high", 32'(tx_pin), 32'd1);
        repeat (BIT) @(negedge clk);
        send(8'h3E, 0, 1'b0, 1'b0);
        rd(8'h18); chk("R11 echo still receives", v, 32'h3E);

        // R11 remote loopback
        wr(8'h04, 32'h3 << 14);
        rx_pin = 1'b0;
        #1 chk("R11 remote low", 32'(tx_pin), 32'd0);
        rx_pin = 1'b1;
        #1 chk("R11 remote high", 32'(tx_pin), 32'd1);
        send(8'hE7, 0, 1'b0, 1'b0);
        rd(8'h14); chk("R11 remote receiver cut off", v & 32'h1, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule